// File: doc/BRIEF.md
# Dual-Direction Mailbox Register Port

This block sits beside a clock-crossing FIFO and gives each of its two ports a single-word mailbox into the other clock domain. Port A, clocked by `clk_a`, posts words into the first mailbox and collects words from the second. Port B, clocked by `clk_b`, does the reverse. Each port has an active-low select, a direction line (1 = write, 0 = read), an enable and a mailbox select. From these the port decides whether an edge is a FIFO access, a mailbox access or nothing. The same lines decide whether the port drives its outgoing data.

The FIFO storage is not part of this block. Port A hands FIFO writes to a request and data stub. Port B raises a read request and passes the stub's output word onto its bus. Each mailbox has an active-low full flag in the writer's domain. A write drops the flag, and the flag blocks further writes. The reader may only take a word after the write has crossed into its domain. Taking the word sends a release back, and the flag rises again once that release has crossed.

The bus of each port is split into an input, an output and an output-enable, so that a pad ring or a tristate wrapper above can make it bidirectional.

Top module: `dual_mailbox_port`

## Requirements
- R1: While a port's select `*_cs_n` is high, that port's output enable is low, its FIFO request is low, and no clock edge changes either mailbox or flag.
- R2: `a_oe` is high exactly when `a_cs_n` is low and `a_wr` is 0, and `a_dout` then carries the second mailbox (written from port B).
- R3: `b_oe` is high exactly when `b_cs_n` is low and `b_wr` is 0. `b_dout` carries the first mailbox when `b_mbx` is 1 and `fifo_rd_data` when `b_mbx` is 0.
- R4: `fifo_wr_req` is high, with `fifo_wr_data` equal to `a_din`, exactly when `a_cs_n` = 0, `a_wr` = 1, `a_en` = 1 and `a_mbx` = 0.
- R5: `fifo_rd_req` is high exactly when `b_cs_n` = 0, `b_wr` = 0, `b_en` = 1 and `b_mbx` = 0.
- R6: A `clk_a` edge with `a_cs_n` = 0, `a_wr` = 1, `a_en` = 1, `a_mbx` = 1 and `mbf1_n` high stores `a_din` in the first mailbox and drives `mbf1_n` low right after that edge.
- R7: A mailbox write is ignored while that mailbox's full flag is low. The stored word and the flag keep their values.
- R8: A `clk_b` edge with `b_cs_n` = 0, `b_wr` = 1, `b_en` = 1, `b_mbx` = 1 and `mbf2_n` high stores `b_din` in the second mailbox and drives `mbf2_n` low right after that edge.
- R9: Taking a posted word releases its flag. For the first mailbox this is a `clk_b` edge with `b_cs_n` = 0, `b_wr` = 0, `b_en` = 1 and `b_mbx` = 1. For the second it is the mirror edge on port A. With two synchronizer stages, the flag rises on the second writer-clock edge after the taking edge.
- R10: A take on either of the first two reader-clock edges after a mailbox write has no effect, because the write has not yet crossed. The full flag stays low.
- R11: Reset drives both full flags high and clears both mailboxes to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock |
| clk_b | input | 1 | Port B clock |
| rst_n | input | 1 | Active-low reset for both domains |
| a_cs_n | input | 1 | Port A select, active low |
| a_wr | input | 1 | Port A direction, 1 = write |
| a_en | input | 1 | Port A enable |
| a_mbx | input | 1 | Port A mailbox select |
| a_din | input | DATA_W | Port A incoming data |
| a_dout | output | DATA_W | Port A outgoing data (second mailbox) |
| a_oe | output | 1 | Port A output enable |
| mbf1_n | output | 1 | First mailbox full, active low, clk_a domain |
| fifo_wr_req | output | 1 | FIFO write request stub |
| fifo_wr_data | output | DATA_W | FIFO write data stub |
| b_cs_n | input | 1 | Port B select, active low |
| b_wr | input | 1 | Port B direction, 1 = write |
| b_en | input | 1 | Port B enable |
| b_mbx | input | 1 | Port B mailbox select |
| b_din | input | DATA_W | Port B incoming data |
| b_dout | output | DATA_W | Port B outgoing data |
| b_oe | output | 1 | Port B output enable |
| mbf2_n | output | 1 | Second mailbox full, active low, clk_b domain |
| fifo_rd_req | output | 1 | FIFO read request stub |
| fifo_rd_data | input | DATA_W | FIFO output word from the stub |

## Verification
The assertions assume two things. First, each port's control lines are settled at the rising edge of that port's own clock. Second, both domains leave reset together, so the toggle pairs start equal. A past-value check on a flag's falling edge is only meaningful under these conditions. The bench changes every control input on the falling clock edge and uses one reset for both sides. It also runs both ports from one clock, so the crossing delays in R9 and R10 land on fixed edges that can be counted.

// File: rtl/mbx_pkg.sv
`timescale 1ns/1ps
package mbx_pkg;
   typedef enum logic [1:0] {
      OP_IDLE   = 2'd0,
      OP_FIFO   = 2'd1,
      OP_BOX_WR = 2'd2,
      OP_BOX_RD = 2'd3
   } port_op_e;
endpackage

// File: rtl/mbx_sync.sv
`timescale 1ns/1ps
// Multi-stage flop chain bringing a level into the destination clock.
module mbx_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("mbx_sync: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/mbx_port_decode.sv
`timescale 1ns/1ps
// Control-line decode for one port; IS_B picks the port-B variant.
module mbx_port_decode
   import mbx_pkg::*;
#(
   parameter bit IS_B = 1'b0
) (
   input  logic     cs_n,
   input  logic     wr,
   input  logic     en,
   input  logic     sel,
   output port_op_e op,
   output logic     oe
);
   logic act;
   assign act = !cs_n && en;
   assign oe  = !cs_n && !wr;

   generate
      if (IS_B) begin : g_port_b
         always_comb begin
            op = OP_IDLE;
            if (act) begin
               if (wr && sel)        op = OP_BOX_WR;
               else if (!wr && sel)  op = OP_BOX_RD;
               else if (!wr && !sel) op = OP_FIFO;
            end
         end
      end else begin : g_port_a
         always_comb begin
            op = OP_IDLE;
            if (act) begin
               if (wr && sel)       op = OP_BOX_WR;
               else if (!wr && sel) op = OP_BOX_RD;
               else if (wr && !sel) op = OP_FIFO;
            end
         end
      end
   endgenerate
endmodule

// File: rtl/mbx_channel.sv
`timescale 1ns/1ps
// One mailbox: storage and toggle in the writer domain, take toggle in the reader domain.
module mbx_channel #(
   parameter int W      = 36,
   parameter int STAGES = 2
) (
   input  logic         w_clk,
   input  logic         w_rst_n,
   input  logic         w_put,
   input  logic [W-1:0] w_data,
   output logic         w_full_n,
   output logic [W-1:0] box_q,
   input  logic         r_clk,
   input  logic         r_rst_n,
   input  logic         r_take
);
   logic put_tgl, take_tgl;
   logic put_seen, take_seen;
   logic r_pending;

   assign w_full_n = (put_tgl == take_seen);

   always_ff @(posedge w_clk or negedge w_rst_n) begin
      if (!w_rst_n) begin
         put_tgl <= 1'b0;
         box_q   <= '0;
      end else if (w_put && w_full_n) begin
         put_tgl <= ~put_tgl;
         box_q   <= w_data;
      end
   end

   mbx_sync #(.STAGES(STAGES)) u_take_sync (
      .clk(w_clk), .rst_n(w_rst_n), .d(take_tgl), .q(take_seen)
   );

   mbx_sync #(.STAGES(STAGES)) u_put_sync (
      .clk(r_clk), .rst_n(r_rst_n), .d(put_tgl), .q(put_seen)
   );

   assign r_pending = (put_seen != take_tgl);

   always_ff @(posedge r_clk or negedge r_rst_n) begin
      if (!r_rst_n)                take_tgl <= 1'b0;
      else if (r_take && r_pending) take_tgl <= ~take_tgl;
   end
endmodule

// File: rtl/dual_mailbox_port.sv
`timescale 1ns/1ps
module dual_mailbox_port
   import mbx_pkg::*;
#(
   parameter int DATA_W      = 36,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk_a,
   input  logic              clk_b,
   input  logic              rst_n,
   input  logic              a_cs_n,
   input  logic              a_wr,
   input  logic              a_en,
   input  logic              a_mbx,
   input  logic [DATA_W-1:0] a_din,
   output logic [DATA_W-1:0] a_dout,
   output logic              a_oe,
   output logic              mbf1_n,
   output logic              fifo_wr_req,
   output logic [DATA_W-1:0] fifo_wr_data,
   input  logic              b_cs_n,
   input  logic              b_wr,
   input  logic              b_en,
   input  logic              b_mbx,
   input  logic [DATA_W-1:0] b_din,
   output logic [DATA_W-1:0] b_dout,
   output logic              b_oe,
   output logic              mbf2_n,
   output logic              fifo_rd_req,
   input  logic [DATA_W-1:0] fifo_rd_data
);
   generate
      if (DATA_W < 1) begin : g_bad_width
         $error("dual_mailbox_port: DATA_W must be positive");
      end
   endgenerate

   port_op_e          op_a, op_b;
   logic [DATA_W-1:0] box1_q, box2_q;

   mbx_port_decode #(.IS_B(1'b0)) u_dec_a (
      .cs_n(a_cs_n), .wr(a_wr), .en(a_en), .sel(a_mbx), .op(op_a), .oe(a_oe)
   );

   mbx_port_decode #(.IS_B(1'b1)) u_dec_b (
      .cs_n(b_cs_n), .wr(b_wr), .en(b_en), .sel(b_mbx), .op(op_b), .oe(b_oe)
   );

   // first mailbox: A writes, B takes
   mbx_channel #(.W(DATA_W), .STAGES(SYNC_STAGES)) u_box1 (
      .w_clk(clk_a), .w_rst_n(rst_n), .w_put(op_a == OP_BOX_WR), .w_data(a_din),
      .w_full_n(mbf1_n), .box_q(box1_q),
      .r_clk(clk_b), .r_rst_n(rst_n), .r_take(op_b == OP_BOX_RD)
   );

   // second mailbox: B writes, A takes
   mbx_channel #(.W(DATA_W), .STAGES(SYNC_STAGES)) u_box2 (
      .w_clk(clk_b), .w_rst_n(rst_n), .w_put(op_b == OP_BOX_WR), .w_data(b_din),
      .w_full_n(mbf2_n), .box_q(box2_q),
      .r_clk(clk_a), .r_rst_n(rst_n), .r_take(op_a == OP_BOX_RD)
   );

   assign fifo_wr_req  = (op_a == OP_FIFO);
   assign fifo_wr_data = a_din;
   assign fifo_rd_req  = (op_b == OP_FIFO);
   assign a_dout       = box2_q;
   assign b_dout       = b_mbx ? box1_q : fifo_rd_data;
endmodule

// File: rtl/mbx_checks.sv
`timescale 1ns/1ps
module mbx_checks #(
   parameter int DATA_W = 36
) (
   input logic              clk_a,
   input logic              clk_b,
   input logic              rst_n,
   input logic              a_cs_n,
   input logic              a_wr,
   input logic              a_en,
   input logic              a_mbx,
   input logic              a_oe,
   input logic              mbf1_n,
   input logic              fifo_wr_req,
   input logic              b_cs_n,
   input logic              b_wr,
   input logic              b_en,
   input logic              b_mbx,
   input logic [DATA_W-1:0] b_dout,
   input logic              b_oe,
   input logic              mbf2_n,
   input logic              fifo_rd_req,
   input logic [DATA_W-1:0] fifo_rd_data
);
   p_idle_a_r1: assert property (@(posedge clk_a) disable iff (!rst_n)
      a_cs_n |-> (!a_oe && !fifo_wr_req));

   p_idle_b_r1: assert property (@(posedge clk_b) disable iff (!rst_n)
      b_cs_n |-> (!b_oe && !fifo_rd_req));

   p_read_drive_r2: assert property (@(posedge clk_a) disable iff (!rst_n)
      (!a_cs_n && !a_wr) |-> a_oe);

   p_fifo_word_r5: assert property (@(posedge clk_b) disable iff (!rst_n)
      fifo_rd_req |-> (b_oe && b_dout == fifo_rd_data));

   p_box1_fill_r6: assert property (@(posedge clk_a) disable iff (!rst_n)
      $fell(mbf1_n) |-> $past(!a_cs_n && a_wr && a_en && a_mbx));

   p_box2_fill_r8: assert property (@(posedge clk_b) disable iff (!rst_n)
      $fell(mbf2_n) |-> $past(!b_cs_n && b_wr && b_en && b_mbx));
endmodule

bind dual_mailbox_port mbx_checks #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/sim_dual_mailbox_port.sv
`timescale 1ns/1ps
module sim_dual_mailbox_port;
   localparam int W = 36;
   localparam logic [W-1:0] FIFO_WORD = 36'hF0F0F0F0F;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic a_cs_n, a_wr, a_en, a_mbx, b_cs_n, b_wr, b_en, b_mbx;
   logic [W-1:0] a_din, b_din, a_dout, b_dout, fifo_wr_data;
   logic a_oe, b_oe, mbf1_n, mbf2_n, fifo_wr_req, fifo_rd_req;
   int total = 0;
   int bad = 0;

   always #2 clk = ~clk;

   dual_mailbox_port u0 (
      .clk_a(clk), .clk_b(clk), .rst_n(rst_n),
      .a_cs_n(a_cs_n), .a_wr(a_wr), .a_en(a_en), .a_mbx(a_mbx), .a_din(a_din),
      .a_dout(a_dout), .a_oe(a_oe), .mbf1_n(mbf1_n),
      .fifo_wr_req(fifo_wr_req), .fifo_wr_data(fifo_wr_data),
      .b_cs_n(b_cs_n), .b_wr(b_wr), .b_en(b_en), .b_mbx(b_mbx), .b_din(b_din),
      .b_dout(b_dout), .b_oe(b_oe), .mbf2_n(mbf2_n),
      .fifo_rd_req(fifo_rd_req), .fifo_rd_data(FIFO_WORD)
   );

   // {cs_n, wr, en, mbx, exp a_oe, exp fifo_wr_req, exp b_oe, exp fifo_rd_req}
   localparam logic [7:0] VEC [16] = '{
      8'b0000_1010, 8'b0001_1010, 8'b0010_1011, 8'b0011_1010,
      8'b0100_0000, 8'b0101_0000, 8'b0110_0100, 8'b0111_0000,
      8'b1000_0000, 8'b1001_0000, 8'b1010_0000, 8'b1011_0000,
      8'b1100_0000, 8'b1101_0000, 8'b1110_0000, 8'b1111_0000
   };

   task automatic chk(input logic [W-1:0] act, input logic [W-1:0] exp, input string tag);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic idle();
      {a_cs_n, a_wr, a_en, a_mbx} = 4'b1000;
      {b_cs_n, b_wr, b_en, b_mbx} = 4'b1000;
   endtask

   task automatic cyc(input int n);
      for (int i = 0; i < n; i++) begin
         @(posedge clk);
         @(negedge clk);
      end
   endtask

   initial begin
      #800000;
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      idle();
      a_din = '0;
      b_din = '0;
      // decode table walked with reset held, so no state moves (R1..R5)
      for (int i = 0; i < 16; i++) begin
         {a_cs_n, a_wr, a_en, a_mbx} = VEC[i][7:4];
         {b_cs_n, b_wr, b_en, b_mbx} = VEC[i][7:4];
         a_din = 36'h123456789 + 36'(i);
         #1;
         chk({35'd0, a_oe}, {35'd0, VEC[i][3]}, $sformatf("R2 a_oe vec%0d", i));
         chk({35'd0, fifo_wr_req}, {35'd0, VEC[i][2]}, $sformatf("R4 fifo_wr_req vec%0d", i));
         chk({35'd0, b_oe}, {35'd0, VEC[i][1]}, $sformatf("R3 b_oe vec%0d", i));
         chk({35'd0, fifo_rd_req}, {35'd0, VEC[i][0]}, $sformatf("R5 fifo_rd_req vec%0d", i));
         if (VEC[i][2]) chk(fifo_wr_data, a_din, "R4 fifo_wr_data");
         if (VEC[i][0]) chk(b_dout, FIFO_WORD, "R5 b_dout fifo word");
         #1;
      end
      idle();
      @(negedge clk);
      rst_n = 1'b1;
      cyc(2);

      // R11 reset state
      chk({35'd0, mbf1_n}, 36'd1, "R11 mbf1_n");
      chk({35'd0, mbf2_n}, 36'd1, "R11 mbf2_n");
      {a_cs_n, a_wr, a_en, a_mbx} = 4'b0000;
      {b_cs_n, b_wr, b_en, b_mbx} = 4'b0001;
      #1;
      chk(a_dout, '0, "R11 second mailbox clear");
      chk(b_dout, '0, "R11 first mailbox clear");
      idle();

      // R6 post into first mailbox
      {a_cs_n, a_wr, a_en, a_mbx} = 4'b0111;
      a_din = 36'hA11111111;
      cyc(1);
      idle();
      chk({35'd0, mbf1_n}, 36'd0, "R6 mbf1_n low after write");
      {b_cs_n, b_wr, b_en, b_mbx} = 4'b0001;
      #1;
      chk(b_dout, 36'hA11111111, "R6 R3 first mailbox on b_dout");
      idle();

      // R7 second write blocked
      {a_cs_n, a_wr, a_en, a_mbx} = 4'b0111;
      a_din = 36'hA22222222;
      cyc(1);
      idle();
      {b_cs_n, b_wr, b_en, b_mbx} = 4'b0001;
      #1;
      chk(b_dout, 36'hA11111111, "R7 blocked write kept word");
      chk({35'd0, mbf1_n}, 36'd0, "R7 flag stays low");
      idle();
      cyc(3);

      // R9 take releases after two clk_a edges
      {b_cs_n, b_wr, b_en, b_mbx} = 4'b0011;
      cyc(1);
      idle();
      chk({35'd0, mbf1_n}, 36'd0, "R9 mbf1_n at take edge");
      cyc(1);
      chk({35'd0, mbf1_n}, 36'd0, "R9 mbf1_n one edge later");
      cyc(1);
      chk({35'd0, mbf1_n}, 36'd1, "R9 mbf1_n released");

      // R10 early take ignored
      {a_cs_n, a_wr, a_en, a_mbx} = 4'b0111;
      a_din = 36'hA33333333;
      cyc(1);
      idle();
      {b_cs_n, b_wr, b_en, b_mbx} = 4'b0011;
      cyc(2);
      idle();
      cyc(6);
      chk({35'd0, mbf1_n}, 36'd0, "R10 early take ignored");
      {b_cs_n, b_wr, b_en, b_mbx} = 4'b0011;
      cyc(1);
      idle();
      cyc(3);
      chk({35'd0, mbf1_n}, 36'd1, "R10 later take releases");

      // R8 mirror: B posts into second mailbox
      {b_cs_n, b_wr, b_en, b_mbx} = 4'b0111;
      b_din = 36'hB44444444;
      cyc(1);
      idle();
      chk({35'd0, mbf2_n}, 36'd0, "R8 mbf2_n low after write");
      {a_cs_n, a_wr, a_en, a_mbx} = 4'b0000;
      #1;
      chk(a_dout, 36'hB44444444, "R8 R2 second mailbox on a_dout");
      idle();
      {b_cs_n, b_wr, b_en, b_mbx} = 4'b0111;
      b_din = 36'hB55555555;
      cyc(1);
      idle();
      chk(a_dout, 36'hB44444444, "R7 blocked second-mailbox write");
      cyc(3);
      {a_cs_n, a_wr, a_en, a_mbx} = 4'b0011;
      cyc(1);
      idle();
      chk({35'd0, mbf2_n}, 36'd0, "R9 mbf2_n at take edge");
      cyc(2);
      chk({35'd0, mbf2_n}, 36'd1, "R9 mbf2_n released");

      // R4 FIFO write request with enable toggling
      {a_cs_n, a_wr, a_en, a_mbx} = 4'b0110;
      a_din = 36'h0DEADBEEF;
      #1;
      chk({35'd0, fifo_wr_req}, 36'd1, "R4 fifo_wr_req high");
      chk(fifo_wr_data, 36'h0DEADBEEF, "R4 fifo_wr_data");
      a_en = 1'b0;
      #1;
      chk({35'd0, fifo_wr_req}, 36'd0, "R4 no request without enable");
      idle();

      // R5 FIFO read request
      {b_cs_n, b_wr, b_en, b_mbx} = 4'b0010;
      #1;
      chk({35'd0, fifo_rd_req}, 36'd1, "R5 fifo_rd_req high");
      chk(b_dout, FIFO_WORD, "R3 b_dout fifo word");
      idle();

      // R1 deselected port ignores a full mailbox write
      {a_cs_n, a_wr, a_en, a_mbx} = 4'b1111;
      a_din = 36'hC66666666;
      #1;
      chk({35'd0, a_oe}, 36'd0, "R1 a_oe low while deselected");
      cyc(2);
      idle();
      chk({35'd0, mbf1_n}, 36'd1, "R1 flag untouched");
      {b_cs_n, b_wr, b_en, b_mbx} = 4'b0001;
      #1;
      chk(b_dout, 36'hA33333333, "R1 mailbox untouched");
      idle();
      {b_cs_n, b_wr, b_en, b_mbx} = 4'b1111;
      b_din = 36'hC77777777;
      cyc(2);
      idle();
      chk({35'd0, mbf2_n}, 36'd1, "R1 port B flag untouched");

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule